// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits just after the receive path has stripped the preamble. It watches the first six bytes of each incoming frame, which form the destination address. From these bytes it decides whether the frame belongs to this station. A frame with `rx_sof` high on its first byte starts a new address. The five valid bytes that follow complete it. Exactly one cycle after the sixth byte, the block raises a one-cycle decision strobe. The strobe carries the accept flag and the class of the destination.

The frame is accepted in any of four cases:

- Promiscuous reception is enabled.
- The destination exactly matches the programmed station address.
- The destination is a broadcast and broadcast reception is not blocked.
- The destination is a group (multicast) address whose bin is set in a 64-bin hash table.

The hash bin is taken from a CRC-32 of the address, which is built up one byte at a time as the address arrives. The hash table is held in two 32-bit words.

Top module: `dst_addr_filter`

## Requirements
- R1: After synchronous reset, `dec_vld` and `dec_accept` are low and stay low until an address has been received.
- R2: `dec_vld` pulses high for exactly one cycle. That cycle is the one after the clock edge that captures the sixth address byte.
- R3: The station address is built from two words. Address byte 0 (the first byte on the wire) is `cfg_sta_hi[15:8]` and byte 1 is `cfg_sta_hi[7:0]`. Bytes 2, 3, 4 and 5 are `cfg_sta_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. A unicast destination is accepted only if all 48 bits match.
- R4: A destination of all ones is a broadcast and reports `dec_class` = 2. With `cfg_bcast_reject` low it is accepted; with it high it is rejected, whatever the hash table holds.
- R5: Any other destination whose byte 0 has bit 0 set is multicast and reports `dec_class` = 1. All remaining destinations are unicast and report `dec_class` = 0.
- R6: The multicast bin index is bits 31:26 of a CRC-32 over the six address bytes. The CRC uses polynomial 0x04C11DB7 and starts from all ones, with no final inversion. Each byte is fed least significant bit first, into the register's bit 31 side. Index bit 5 selects the word (0: `cfg_hash_lo`, 1: `cfg_hash_hi`), and index bits 4:0 select the bit within it. A multicast frame is accepted when that bit is set.
- R7: When both hash words are all ones, every multicast destination is accepted.
- R8: With `cfg_promisc` high, every frame is accepted, including a blocked broadcast and a unicast that does not match.
- R9: A byte with `rx_sof` high always restarts address collection, even in the middle of an address. Valid bytes after the sixth byte are ignored until the next `rx_sof`, and they cause no further decision.
- R10: Cycles with `rx_byte_vld` low are ignored, so gaps between address bytes do not change the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte_vld | input | 1 | Byte strobe for `rx_byte` |
| rx_sof | input | 1 | Marks the first byte of a frame (qualified by `rx_byte_vld`) |
| rx_byte | input | 8 | Received byte |
| cfg_promisc | input | 1 | Accept all frames (mode register bit 5) |
| cfg_bcast_reject | input | 1 | Reject broadcast frames (mode register bit 3) |
| cfg_sta_lo | input | 32 | Station address bytes 2..5 |
| cfg_sta_hi | input | 16 | Station address bytes 0..1 |
| cfg_hash_lo | input | 32 | Hash bins 0..31 |
| cfg_hash_hi | input | 32 | Hash bins 32..63 |
| dec_vld | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_class | output | 2 | 0 unicast, 1 multicast, 2 broadcast |

## Verification
Some properties are checked on every cycle:

- the one-cycle latency and single-pulse shape of the decision strobe;
- the legal class codes;
- the override by promiscuous mode;
- the veto on blocked broadcasts;
- acceptance of every multicast when the hash is full;
- the byte position counter staying in range.

Other behaviour can only be shown by the directed scenarios. These are the byte order of the station address, the exact 48-bit unicast compare, and the CRC-derived bin selection across both hash words. The scenarios also cover restart on a mid-address start marker, the ignoring of trailing bytes, and tolerance of gaps in the byte stream.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;

    localparam int OCTET_W    = 8;
    localparam int CRC_W      = 32;
    localparam int BIN_IDX_W  = 6;
    localparam int HASH_WORD_W = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

    typedef enum logic [1:0] {
        DST_UNI   = 2'd0,
        DST_GRP   = 2'd1,
        DST_BCAST = 2'd2
    } dst_kind_e;

    typedef struct packed {
        logic promisc;
        logic bcast_block;
    } mode_cfg_t;

    typedef struct packed {
        logic      accept;
        dst_kind_e kind;
    } verdict_t;

    // Advance the CRC by one byte, least significant data bit first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [OCTET_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int b = 0; b < OCTET_W; b++) begin
            if (r[CRC_W-1] ^ d[b])
                r = (r << 1) ^ CRC_POLY;
            else
                r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/dst_crc_accum.sv
module dst_crc_accum
    import addr_filt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               take,
    input  logic [OCTET_W-1:0] data,
    output logic [CRC_W-1:0]   crc_nx
);
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] seed;

    always_comb begin
        seed   = start ? '1 : crc_q;
        crc_nx = crc_step(seed, data);
    end

    always_ff @(posedge clk) begin
        if (rst)
            crc_q <= '1;
        else if (take)
            crc_q <= crc_nx;
    end
endmodule

// File: rtl/dst_tracker.sv
module dst_tracker
    import addr_filt_pkg::*;
#(
    parameter int ADDR_BYTES = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          byte_vld,
    input  logic                          sof,
    input  logic [OCTET_W-1:0]            data,
    input  logic [ADDR_BYTES*OCTET_W-1:0] sta,
    output logic                          start,
    output logic                          take,
    output logic                          last,
    output logic                          eq_nx,
    output logic                          ones_nx,
    output logic                          grp_nx
);
    localparam int POS_W = $clog2(ADDR_BYTES + 1);
    localparam logic [POS_W-1:0] IDLE_POS = POS_W'(ADDR_BYTES);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(ADDR_BYTES - 1);

    logic [OCTET_W-1:0] sta_b [ADDR_BYTES];
    logic [POS_W-1:0]   pos_q, cur_pos;
    logic               eq_q, ones_q, grp_q;

    // Byte 0 (first on the wire) is the most significant byte of sta.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_sta_split
        assign sta_b[g] = sta[OCTET_W*(ADDR_BYTES-1-g) +: OCTET_W];
    end

    always_comb begin
        start   = byte_vld && sof;
        take    = byte_vld && (sof || (pos_q != IDLE_POS));
        cur_pos = sof ? '0 : pos_q;
        last    = take && (cur_pos == LAST_POS);
        eq_nx   = (start ? 1'b1 : eq_q) && (data == sta_b[cur_pos]);
        ones_nx = (start ? 1'b1 : ones_q) && (&data);
        grp_nx  = start ? data[0] : grp_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= IDLE_POS;
            eq_q   <= 1'b0;
            ones_q <= 1'b0;
            grp_q  <= 1'b0;
        end else if (take) begin
            pos_q  <= cur_pos + 1'b1;
            eq_q   <= eq_nx;
            ones_q <= ones_nx;
            grp_q  <= grp_nx;
        end
    end

    p_pos_range_r9: assert property (@(posedge clk) disable iff (rst)
        pos_q <= IDLE_POS)
        else $error("p_pos_range_r9: byte position out of range");

    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> (pos_q == POS_W'(1)))
        else $error("p_restart_r9: start marker did not restart collection");
endmodule

// File: rtl/dst_decide.sv
module dst_decide
    import addr_filt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   last,
    input  logic                   eq,
    input  logic                   ones,
    input  logic                   grp,
    input  logic [CRC_W-1:0]       crc,
    input  mode_cfg_t              mode,
    input  logic [HASH_WORD_W-1:0] hash_lo,
    input  logic [HASH_WORD_W-1:0] hash_hi,
    output logic                   dec_vld,
    output verdict_t               verdict
);
    localparam int SEL_W = BIN_IDX_W - 1;

    logic [BIN_IDX_W-1:0] bin;
    logic                 bin_hit;
    verdict_t             v_nx;

    always_comb begin
        bin     = crc[CRC_W-1 -: BIN_IDX_W];
        bin_hit = bin[BIN_IDX_W-1] ? hash_hi[bin[SEL_W-1:0]] : hash_lo[bin[SEL_W-1:0]];
        if (ones)
            v_nx.kind = DST_BCAST;
        else if (grp)
            v_nx.kind = DST_GRP;
        else
            v_nx.kind = DST_UNI;
        unique case (v_nx.kind)
            DST_BCAST: v_nx.accept = !mode.bcast_block;
            DST_GRP:   v_nx.accept = bin_hit;
            default:   v_nx.accept = eq;
        endcase
        if (mode.promisc)
            v_nx.accept = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_vld <= 1'b0;
            verdict <= '{accept: 1'b0, kind: DST_UNI};
        end else begin
            dec_vld <= last;
            if (last)
                verdict <= v_nx;
        end
    end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
    import addr_filt_pkg::*;
#(
    parameter int ADDR_BYTES = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_byte_vld,
    input  logic        rx_sof,
    input  logic [7:0]  rx_byte,
    input  logic        cfg_promisc,
    input  logic        cfg_bcast_reject,
    input  logic [31:0] cfg_sta_lo,
    input  logic [15:0] cfg_sta_hi,
    input  logic [31:0] cfg_hash_lo,
    input  logic [31:0] cfg_hash_hi,
    output logic        dec_vld,
    output logic        dec_accept,
    output logic [1:0]  dec_class
);
    logic             t_start, t_take, t_last, t_eq, t_ones, t_grp;
    logic [CRC_W-1:0] crc_nx;
    mode_cfg_t        mode;
    verdict_t         verdict;

    assign mode = '{promisc: cfg_promisc, bcast_block: cfg_bcast_reject};

    dst_tracker #(.ADDR_BYTES(ADDR_BYTES)) u_trk (
        .clk     (clk),
        .rst     (rst),
        .byte_vld(rx_byte_vld),
        .sof     (rx_sof),
        .data    (rx_byte),
        .sta     ({cfg_sta_hi, cfg_sta_lo}),
        .start   (t_start),
        .take    (t_take),
        .last    (t_last),
        .eq_nx   (t_eq),
        .ones_nx (t_ones),
        .grp_nx  (t_grp)
    );

    dst_crc_accum u_crc (
        .clk   (clk),
        .rst   (rst),
        .start (t_start),
        .take  (t_take),
        .data  (rx_byte),
        .crc_nx(crc_nx)
    );

    dst_decide u_dec (
        .clk    (clk),
        .rst    (rst),
        .last   (t_last),
        .eq     (t_eq),
        .ones   (t_ones),
        .grp    (t_grp),
        .crc    (crc_nx),
        .mode   (mode),
        .hash_lo(cfg_hash_lo),
        .hash_hi(cfg_hash_hi),
        .dec_vld(dec_vld),
        .verdict(verdict)
    );

    assign dec_accept = verdict.accept;
    assign dec_class  = verdict.kind;

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        t_last |=> dec_vld)
        else $error("p_latency_r2: no decision after sixth byte");

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        dec_vld |-> $past(t_last))
        else $error("p_no_spurious_r2: decision without sixth byte");

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        dec_vld |=> !dec_vld)
        else $error("p_single_pulse_r9: decision strobe longer than one cycle");

    p_class_legal_r5: assert property (@(posedge clk) disable iff (rst)
        dec_vld |-> (dec_class != 2'd3))
        else $error("p_class_legal_r5: illegal class code");

    p_promisc_r8: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && $past(cfg_promisc)) |-> dec_accept)
        else $error("p_promisc_r8: promiscuous frame rejected");

    p_bcast_block_r4: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && dec_class == 2'd2 && $past(cfg_bcast_reject) && !$past(cfg_promisc))
            |-> !dec_accept)
        else $error("p_bcast_block_r4: blocked broadcast accepted");

    p_hash_full_r7: assert property (@(posedge clk) disable iff (rst)
        (dec_vld && dec_class == 2'd1 && $past(&{cfg_hash_hi, cfg_hash_lo})) |-> dec_accept)
        else $error("p_hash_full_r7: multicast rejected with full hash");
endmodule

// File: tb/tb_dst_addr_filter.sv
module tb_dst_addr_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_byte_vld = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        cfg_promisc = 1'b0;
    logic        cfg_bcast_reject = 1'b0;
    logic [31:0] cfg_sta_lo = 32'h3456789A;
    logic [15:0] cfg_sta_hi = 16'h0212;
    logic [31:0] cfg_hash_lo = 32'h0;
    logic [31:0] cfg_hash_hi = 32'h0;
    logic        dec_vld, dec_accept;
    logic [1:0]  dec_class;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [47:0] STATION = 48'h0212_3456_789A;
    localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

    always #10 clk = ~clk;

    dst_addr_filter dut (
        .clk(clk), .rst(rst), .rx_byte_vld(rx_byte_vld), .rx_sof(rx_sof),
        .rx_byte(rx_byte), .cfg_promisc(cfg_promisc),
        .cfg_bcast_reject(cfg_bcast_reject), .cfg_sta_lo(cfg_sta_lo),
        .cfg_sta_hi(cfg_sta_hi), .cfg_hash_lo(cfg_hash_lo),
        .cfg_hash_hi(cfg_hash_hi), .dec_vld(dec_vld),
        .dec_accept(dec_accept), .dec_class(dec_class)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Bin index per R6: CRC over address bits, bytes in wire order, LSB first.
    function automatic logic [5:0] bin_of(input logic [47:0] a);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            fb = c[31] ^ a[40 - 8*(i/8) + (i%8)];
            c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
        end
        return c[31:26];
    endfunction

    function automatic logic [1:0] kind_of(input logic [47:0] a);
        if (a == BCAST) return 2'd2;
        if (a[40])      return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic model_accept(input logic [47:0] a);
        logic [5:0] b;
        b = bin_of(a);
        if (cfg_promisc) return 1'b1;
        case (kind_of(a))
            2'd2:    return !cfg_bcast_reject;
            2'd1:    return b[5] ? cfg_hash_hi[b[4:0]] : cfg_hash_lo[b[4:0]];
            default: return a == {cfg_sta_hi, cfg_sta_lo};
        endcase
    endfunction

    task automatic drive_bytes(input logic [47:0] a, input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_byte_vld = 1'b1;
            rx_sof      = (i == 0);
            rx_byte     = a[47 - 8*i -: 8];
            if (i < n - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    rx_byte_vld = 1'b0;
                    rx_sof      = 1'b0;
                    rx_byte     = 8'hA5;
                end
            end
        end
        @(negedge clk);
        rx_byte_vld = 1'b0;
        rx_sof      = 1'b0;
    endtask

    task automatic run_frame(input logic [47:0] a, input int gap, input string req);
        logic       ea;
        logic [1:0] ek;
        ea = model_accept(a);
        ek = kind_of(a);
        drive_bytes(a, 6, gap);
        chk(dec_vld == 1'b1, req, "decision strobe", 32'(dec_vld), 32'd1);
        chk(dec_accept == ea, req, "accept", 32'(dec_accept), 32'(ea));
        chk(dec_class == ek, req, "class", 32'(dec_class), 32'(ek));
        @(negedge clk);
        chk(dec_vld == 1'b0, "R2", "strobe width", 32'(dec_vld), 32'd0);
    endtask

    task automatic t_reset();
        chk(dec_vld == 1'b0, "R1", "vld after reset", 32'(dec_vld), 32'd0);
        chk(dec_accept == 1'b0, "R1", "accept after reset", 32'(dec_accept), 32'd0);
        repeat (3) @(negedge clk);
        chk(dec_vld == 1'b0, "R1", "vld idle", 32'(dec_vld), 32'd0);
    endtask

    task automatic t_unicast();
        run_frame(STATION, 0, "R3");
        chk(dec_accept == 1'b1 && model_accept(STATION), "R3", "station accepted", 32'(dec_accept), 32'd1);
        run_frame(STATION ^ 48'h1, 0, "R3");
        run_frame(STATION ^ 48'h0200_0000_0000, 0, "R3");
        run_frame(48'h3456_789A_0212, 0, "R3");
    endtask

    task automatic t_broadcast();
        cfg_bcast_reject = 1'b0;
        run_frame(BCAST, 0, "R4");
        cfg_bcast_reject = 1'b1;
        cfg_hash_lo = '1;
        cfg_hash_hi = '1;
        run_frame(BCAST, 0, "R4");
        chk(dec_accept == 1'b0, "R4", "blocked broadcast", 32'(dec_accept), 32'd0);
        cfg_hash_lo = '0;
        cfg_hash_hi = '0;
        cfg_bcast_reject = 1'b0;
    endtask

    task automatic t_classes();
        run_frame(48'hFFFF_FFFF_FFFE, 0, "R5");
        run_frame(48'hFEFF_FFFF_FFFF, 0, "R5");
        run_frame(48'h0100_5E00_0001, 0, "R5");
    endtask

    task automatic t_hash();
        logic [47:0] a;
        logic [5:0]  b;
        for (int k = 0; k < 8; k++) begin
            a = {8'h01 + 8'(2*k), 8'h00, 8'h5E, 8'(k*37), 8'(k*11), 8'(k+3)};
            b = bin_of(a);
            cfg_hash_lo = '0;
            cfg_hash_hi = '0;
            if (b[5]) cfg_hash_hi[b[4:0]] = 1'b1; else cfg_hash_lo[b[4:0]] = 1'b1;
            run_frame(a, 0, "R6");
            chk(dec_accept == 1'b1, "R6", "bin set", 32'(dec_accept), 32'd1);
            cfg_hash_lo = ~cfg_hash_lo;
            cfg_hash_hi = ~cfg_hash_hi;
            run_frame(a, 0, "R6");
            chk(dec_accept == 1'b0, "R6", "bin clear", 32'(dec_accept), 32'd0);
            cfg_hash_lo = '0;
            cfg_hash_hi = '0;
            if (b[5]) cfg_hash_lo[b[4:0]] = 1'b1; else cfg_hash_hi[b[4:0]] = 1'b1;
            run_frame(a, 0, "R6");
            chk(dec_accept == 1'b0, "R6", "wrong word", 32'(dec_accept), 32'd0);
        end
        cfg_hash_lo = '0;
        cfg_hash_hi = '0;
    endtask

    task automatic t_hash_full();
        cfg_hash_lo = '1;
        cfg_hash_hi = '1;
        run_frame(48'h0100_5E7F_0102, 0, "R7");
        run_frame(48'h3333_0000_00FB, 0, "R7");
        chk(dec_accept == 1'b1, "R7", "full hash", 32'(dec_accept), 32'd1);
        cfg_hash_lo = '0;
        cfg_hash_hi = '0;
    endtask

    task automatic t_promisc();
        cfg_promisc = 1'b1;
        cfg_bcast_reject = 1'b1;
        run_frame(48'h0A0B_0C0D_0E0F, 0, "R8");
        run_frame(BCAST, 0, "R8");
        run_frame(48'h0100_5E00_0042, 0, "R8");
        chk(dec_accept == 1'b1, "R8", "promisc multicast", 32'(dec_accept), 32'd1);
        cfg_promisc = 1'b0;
        cfg_bcast_reject = 1'b0;
    endtask

    task automatic t_restart();
        drive_bytes(48'h0212_3400_0000, 3, 0);
        chk(dec_vld == 1'b0, "R9", "no decision on partial", 32'(dec_vld), 32'd0);
        run_frame(48'h0A0B_0C0D_0E0F, 0, "R9");
        drive_bytes(48'h0212_0000_0000, 4, 0);
        run_frame(STATION, 0, "R9");
        chk(dec_accept == 1'b1, "R9", "restart accept", 32'(dec_accept), 32'd1);
        for (int i = 0; i < 5; i++) begin
            rx_byte_vld = 1'b1;
            rx_sof      = 1'b0;
            rx_byte     = 8'(i + 1);
            @(negedge clk);
            chk(dec_vld == 1'b0, "R9", "trailing byte ignored", 32'(dec_vld), 32'd0);
        end
        rx_byte_vld = 1'b0;
        @(negedge clk);
        chk(dec_vld == 1'b0, "R9", "no late decision", 32'(dec_vld), 32'd0);
    endtask

    task automatic t_gaps();
        run_frame(STATION, 3, "R10");
        chk(dec_accept == 1'b1, "R10", "gapped station", 32'(dec_accept), 32'd1);
        run_frame(STATION ^ 48'h0000_0000_0100, 2, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_broadcast();
        t_classes();
        t_hash();
        t_hash_full();
        t_promisc();
        t_restart();
        t_gaps();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule